// File: doc/BRIEF.md
# Inter-processor mailbox send engine

The engine turns a single 64-bit send command into a 32-bit store into the register space of one processor core. Software writes the command to one of two command addresses. The mail command address selects one of eight mailbox words at a fixed base. The direct command address carries a full 16-bit target offset. Either kind can carry a per-byte keep mask. When any keep bit is set, the engine first reads the current target word. It then writes back a word in which the kept bytes hold their old value and every other byte comes from the payload.

Commands enter on a valid/ready port. The engine holds `cmd_ready` high only while it is idle, so exactly one command is in flight. Each accepted command yields one response beat on `rsp_valid` with an error flag. The response is held until `rsp_ready` is high. On the core side, the engine presents a request with `bus_req_valid`. The request fields stay stable until `bus_req_ready` is seen high at a clock edge. The register blocks answer each request with a one-cycle `bus_rsp_valid` pulse that carries read data and an error flag. The engine always accepts that pulse.

The command is rejected without touching the bus in two cases: it was written to an address that is neither command address, or it names a core that does not exist. A failed read ends the command without a write. The outcome of the write itself is reported back as the command's error.

Top module: `ipi_send_engine`

## Requirements
- R1: `cmd_ready` is high only when no command is in flight; the cycle after a command is accepted, `cmd_ready` is low, and it stays low until that command's response has been taken.
- R2: The target core is command bits [25:16]. If that value is not below NUM_CORES, the response has error = 1 and no bus request is issued.
- R3: A command written to any address other than MAIL_CMD_ADDR or ANY_CMD_ADDR gets a response with error = 1 and issues no bus request.
- R4: For a command at MAIL_CMD_ADDR, the target offset is MBOX_BASE + 4 × (command bits [4:2]). Command bits [1:0] and [15:5] do not affect the offset.
- R5: For a command at ANY_CMD_ADDR, the target offset is command bits [15:0].
- R6: The payload is command bits [63:32]. When keep bits [30:27] are all zero, the engine issues exactly one write of the payload and no read. Bits 26 and 31 have no effect.
- R7: When any keep bit is nonzero, the engine issues a read of the target first and then a write. In that write, byte lane i (bits 8i+7:8i) equals the old byte if command bit 27+i is 1, and the payload byte otherwise.
- R8: An error on the read response ends the command with response error = 1 and issues no write.
- R9: The response error of a command that reaches the write equals the error flag of the write response.
- R10: While `bus_req_valid` is high and `bus_req_ready` is low, the request and all its fields stay unchanged. While `rsp_valid` is high and `rsp_ready` is low, the response and its error flag stay unchanged.
- R11: After reset, `cmd_ready` is 1, and `bus_req_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken at this edge if valid |
| cmd_addr | input | CMD_AW | Command address the command was written to |
| cmd_data | input | 64 | Send command word |
| rsp_valid | output | 1 | Command result available |
| rsp_ready | input | 1 | Result taken at this edge |
| rsp_err | output | 1 | Command failed |
| bus_req_valid | output | 1 | Register-bus request pending |
| bus_req_ready | input | 1 | Register block accepts request |
| bus_req_write | output | 1 | 1 = write, 0 = read |
| bus_req_core | output | 10 | Target core number |
| bus_req_addr | output | 16 | Target offset inside the core's register space |
| bus_req_wdata | output | 32 | Write data |
| bus_rsp_valid | input | 1 | One-cycle response from register block |
| bus_rsp_err | input | 1 | Response reports failure |
| bus_rsp_rdata | input | 32 | Read data |

## Verification
The bench builds the engine with NUM_CORES = 4, MBOX_BASE = 16'h0020 and command addresses 8'h10 and 8'h18. The small core count puts core 4, the first nonexistent core, right next to valid ones, and core 0x3FF tests the top of the field. Irregular back-pressure patterns on `bus_req_ready` and `rsp_ready` hold requests and responses across several edges. This exercises the stability rules while reads, merges and error injections on either bus phase are in flight.

// File: rtl/ipi_send_pkg.sv
package ipi_send_pkg;
  localparam int CMD_W    = 64;
  localparam int WORD_W   = 32;
  localparam int TGT_AW   = 16;
  localparam int CORE_W   = 10;
  localparam int LANES    = WORD_W / 8;
  localparam int CORE_LSB = 16;
  localparam int IDX_LSB  = 2;
  localparam int IDX_W    = 3;
  localparam int KEEP_LSB = 27;
  localparam int PAY_LSB  = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_RESP
  } send_state_t;

  typedef struct packed {
    logic              reject;
    logic [CORE_W-1:0] core;
    logic [TGT_AW-1:0] addr;
    logic [WORD_W-1:0] payload;
    logic [LANES-1:0]  keep;
  } send_job_t;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_send_pkg::*;
#(
  parameter int                CMD_AW        = 8,
  parameter logic [CMD_AW-1:0] MAIL_CMD_ADDR = 8'h10,
  parameter logic [CMD_AW-1:0] ANY_CMD_ADDR  = 8'h18,
  parameter logic [TGT_AW-1:0] MBOX_BASE     = 16'h0020,
  parameter int                NUM_CORES     = 4
) (
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [CMD_W-1:0]  cmd_data,
  output send_job_t         job
);
  localparam int PAD_W = TGT_AW - IDX_W - 2;

  logic             is_mail;
  logic             is_any;
  logic             core_ok;
  logic [IDX_W-1:0] idx;
  logic             unused_cmd_bits;

  assign unused_cmd_bits = ^{cmd_data[31], cmd_data[26]};

  always_comb begin
    is_mail     = (cmd_addr == MAIL_CMD_ADDR);
    is_any      = (cmd_addr == ANY_CMD_ADDR);
    job.core    = cmd_data[CORE_LSB +: CORE_W];
    core_ok     = 32'(job.core) < 32'(NUM_CORES);
    idx         = cmd_data[IDX_LSB +: IDX_W];
    job.payload = cmd_data[PAY_LSB +: WORD_W];
    job.keep    = cmd_data[KEEP_LSB +: LANES];
    if (is_mail) job.addr = MBOX_BASE + {{PAD_W{1'b0}}, idx, 2'b00};
    else         job.addr = cmd_data[0 +: TGT_AW];
    job.reject  = !(is_mail || is_any) || !core_ok;
  end
endmodule

// File: rtl/ipi_lane_merge.sv
module ipi_lane_merge
  import ipi_send_pkg::*;
(
  input  logic [WORD_W-1:0] old_word,
  input  logic [WORD_W-1:0] new_word,
  input  logic [LANES-1:0]  keep,
  output logic [WORD_W-1:0] merged
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*8 +: 8] = keep[l] ? old_word[l*8 +: 8] : new_word[l*8 +: 8];
  end
endmodule

// File: rtl/ipi_send_ctrl.sv
module ipi_send_ctrl
  import ipi_send_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  send_job_t         job_in,
  output send_job_t         job_q,
  input  logic [WORD_W-1:0] merged,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_write,
  output logic [CORE_W-1:0] bus_req_core,
  output logic [TGT_AW-1:0] bus_req_addr,
  output logic [WORD_W-1:0] bus_req_wdata,
  input  logic              bus_rsp_valid,
  input  logic              bus_rsp_err,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err
);
  send_state_t       state;
  logic [WORD_W-1:0] wdata_q;
  logic              err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      job_q   <= '0;
      wdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_valid) begin
          job_q   <= job_in;
          wdata_q <= job_in.payload;
          err_q   <= job_in.reject;
          if (job_in.reject)    state <= ST_RESP;
          else if (|job_in.keep) state <= ST_RD_REQ;
          else                   state <= ST_WR_REQ;
        end
        ST_RD_REQ: if (bus_req_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (bus_rsp_valid) begin
          if (bus_rsp_err) begin
            err_q <= 1'b1;
            state <= ST_RESP;
          end else begin
            wdata_q <= merged;
            state   <= ST_WR_REQ;
          end
        end
        ST_WR_REQ: if (bus_req_ready) state <= ST_WR_WAIT;
        ST_WR_WAIT: if (bus_rsp_valid) begin
          err_q <= bus_rsp_err;
          state <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_ready     = (state == ST_IDLE);
    bus_req_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
    bus_req_write = (state == ST_WR_REQ);
    bus_req_core  = job_q.core;
    bus_req_addr  = job_q.addr;
    bus_req_wdata = wdata_q;
    rsp_valid     = (state == ST_RESP);
    rsp_err       = err_q;
  end
endmodule

// File: rtl/ipi_send_engine.sv
module ipi_send_engine
  import ipi_send_pkg::*;
#(
  parameter int                CMD_AW        = 8,
  parameter logic [CMD_AW-1:0] MAIL_CMD_ADDR = 8'h10,
  parameter logic [CMD_AW-1:0] ANY_CMD_ADDR  = 8'h18,
  parameter logic [15:0]       MBOX_BASE     = 16'h0020,
  parameter int                NUM_CORES     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [63:0]       cmd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_write,
  output logic [9:0]        bus_req_core,
  output logic [15:0]       bus_req_addr,
  output logic [31:0]       bus_req_wdata,
  input  logic              bus_rsp_valid,
  input  logic              bus_rsp_err,
  input  logic [31:0]       bus_rsp_rdata
);
  send_job_t         job_dec;
  send_job_t         job_q;
  logic [WORD_W-1:0] merged;

  ipi_cmd_decode #(
    .CMD_AW(CMD_AW), .MAIL_CMD_ADDR(MAIL_CMD_ADDR), .ANY_CMD_ADDR(ANY_CMD_ADDR),
    .MBOX_BASE(MBOX_BASE), .NUM_CORES(NUM_CORES)
  ) u_dec (
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .job(job_dec)
  );

  ipi_lane_merge u_merge (
    .old_word(bus_rsp_rdata), .new_word(job_q.payload), .keep(job_q.keep), .merged(merged)
  );

  ipi_send_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .job_in(job_dec), .job_q(job_q), .merged(merged),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_write(bus_req_write), .bus_req_core(bus_req_core),
    .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err)
  );
endmodule

// File: rtl/ipi_send_engine_chk.sv
module ipi_send_engine_chk #(
  parameter int NUM_CORES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_err,
  input logic        bus_req_valid,
  input logic        bus_req_ready,
  input logic        bus_req_write,
  input logic [9:0]  bus_req_core,
  input logic [15:0] bus_req_addr,
  input logic [31:0] bus_req_wdata,
  input logic        bus_rsp_valid,
  input logic        bus_rsp_err
);
  logic rd_pend;
  logic wr_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
    end else begin
      if (bus_req_valid && bus_req_ready && !bus_req_write) rd_pend <= 1'b1;
      else if (bus_rsp_valid)                                rd_pend <= 1'b0;
      if (bus_req_valid && bus_req_ready && bus_req_write)   wr_pend <= 1'b1;
      else if (bus_rsp_valid)                                wr_pend <= 1'b0;
    end
  end

  p_busy_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  p_core_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> (32'(bus_req_core) < 32'(NUM_CORES)));

  p_write_follows_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend && bus_rsp_valid && !bus_rsp_err |=> bus_req_valid && bus_req_write);

  p_read_err_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend && bus_rsp_valid && bus_rsp_err |=> rsp_valid && rsp_err && !bus_req_valid);

  p_write_err_reported_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend && bus_rsp_valid |=> rsp_valid && (rsp_err == $past(bus_rsp_err)));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_write)
      && $stable(bus_req_core) && $stable(bus_req_addr) && $stable(bus_req_wdata));

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_err));
endmodule

bind ipi_send_engine ipi_send_engine_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
  .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
  .bus_req_write(bus_req_write), .bus_req_core(bus_req_core),
  .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
  .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err)
);

// File: tb/ipi_send_engine_test.sv
`timescale 1ns/1ps
module ipi_send_engine_test;
  localparam int          NC   = 4;
  localparam logic [7:0]  MAIL = 8'h10;
  localparam logic [7:0]  ANY  = 8'h18;
  localparam logic [15:0] BASE = 16'h0020;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [7:0] cmd_addr = '0;
  logic [63:0] cmd_data = '0;
  logic rsp_valid, rsp_ready = 1'b1, rsp_err;
  logic bus_req_valid, bus_req_ready = 1'b1, bus_req_write;
  logic [9:0] bus_req_core;
  logic [15:0] bus_req_addr;
  logic [31:0] bus_req_wdata;
  logic bus_rsp_valid = 1'b0, bus_rsp_err = 1'b0;
  logic [31:0] bus_rsp_rdata = '0;

  always #4 clk = ~clk;

  ipi_send_engine #(.CMD_AW(8), .MAIL_CMD_ADDR(MAIL), .ANY_CMD_ADDR(ANY),
    .MBOX_BASE(BASE), .NUM_CORES(NC)) uut (.*);

  int checks = 0, errors = 0;
  string cur_tag = "";
  logic [58:0] exp_bus[$];
  logic exp_rsp[$];
  int rsp_seen = 0, rsp_issued = 0;
  bit inj_rd = 0, inj_wr = 0, bp_on = 0;
  logic [15:0] req_pat = 16'b1001_0110_0010_1101;
  logic [15:0] rsp_pat = 16'b0110_1001_1100_0101;
  bit pend = 0, pend_wr = 0;
  logic [9:0] pend_core;
  logic [15:0] pend_addr;
  bit done = 0;

  function automatic logic [31:0] rd_model(input logic [9:0] c, input logic [15:0] a);
    return {a ^ 16'hC3A5, 6'd0, c};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // register-bus responder and request monitor
  always @(negedge clk) begin
    if (pend) begin
      bus_rsp_valid <= 1'b1;
      bus_rsp_err   <= pend_wr ? inj_wr : inj_rd;
      bus_rsp_rdata <= pend_wr ? 32'h0 : rd_model(pend_core, pend_addr);
      pend = 0;
    end else begin
      bus_rsp_valid <= 1'b0;
      bus_rsp_err   <= 1'b0;
    end
    if (bp_on) begin
      req_pat = {req_pat[14:0], req_pat[15]};
      bus_req_ready = req_pat[0];
    end else bus_req_ready = 1'b1;
    if (rst_n && bus_req_valid && bus_req_ready) begin
      pend = 1; pend_wr = bus_req_write;
      pend_core = bus_req_core; pend_addr = bus_req_addr;
      if (exp_bus.size() == 0) begin
        chk(0, {cur_tag, " unexpected bus request"},
            {5'd0, bus_req_write, bus_req_core, bus_req_addr, bus_req_wdata}, 64'h0);
      end else begin
        logic [58:0] e;
        e = exp_bus.pop_front();
        if (e[58])
          chk(bus_req_write && bus_req_core == e[57:48] && bus_req_addr == e[47:32]
              && bus_req_wdata == e[31:0], {cur_tag, " write request"},
              {5'd0, bus_req_write, bus_req_core, bus_req_addr, bus_req_wdata}, {5'd0, e});
        else
          chk(!bus_req_write && bus_req_core == e[57:48] && bus_req_addr == e[47:32],
              {cur_tag, " read request"},
              {5'd0, bus_req_write, bus_req_core, bus_req_addr, 32'h0}, {5'd0, e[58:32], 32'h0});
      end
    end
  end

  // response monitor
  always @(negedge clk) begin
    if (bp_on) begin
      rsp_pat = {rsp_pat[14:0], rsp_pat[15]};
      rsp_ready = rsp_pat[0];
    end else rsp_ready = 1'b1;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_rsp.size() == 0)
        chk(0, {cur_tag, " unexpected response"}, {63'd0, rsp_err}, 64'h0);
      else begin
        logic e;
        e = exp_rsp.pop_front();
        chk(rsp_err == e, {cur_tag, " response error flag"}, {63'd0, rsp_err}, {63'd0, e});
      end
      rsp_seen++;
    end
  end

  task automatic send(input logic [7:0] a, input logic [63:0] d,
                      input bit rderr, input bit wrerr, input string tag);
    logic [9:0] core;
    logic [3:0] keep;
    logic [31:0] pay, old, mg;
    logic [15:0] ta;
    bit hs;
    cur_tag = tag;
    core = d[25:16]; keep = d[30:27]; pay = d[63:32];
    inj_rd = rderr; inj_wr = wrerr;
    if (!(a == MAIL || a == ANY) || core >= NC) exp_rsp.push_back(1'b1);
    else begin
      ta = (a == MAIL) ? BASE + {11'd0, d[4:2], 2'b00} : d[15:0];
      mg = pay;
      if (keep != 0) begin
        exp_bus.push_back({1'b0, core, ta, 32'h0});
        old = rd_model(core, ta);
        for (int l = 0; l < 4; l++) if (keep[l]) mg[l*8 +: 8] = old[l*8 +: 8];
      end
      if (keep != 0 && rderr) exp_rsp.push_back(1'b1);
      else begin
        exp_bus.push_back({1'b1, core, ta, mg});
        exp_rsp.push_back(wrerr);
      end
    end
    rsp_issued++;
    cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
    do begin
      hs = cmd_ready;
      @(negedge clk);
    end while (!hs);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, {tag, " R1 busy after accept"}, {63'd0, cmd_ready}, 64'h0);
    while (rsp_seen < rsp_issued) @(negedge clk);
    chk(exp_bus.size() == 0, {tag, " all bus ops seen"}, exp_bus.size(), 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R11 reset cmd_ready", {63'd0, cmd_ready}, 64'h1);
    chk(bus_req_valid == 1'b0, "R11 reset bus_req_valid", {63'd0, bus_req_valid}, 64'h0);
    chk(rsp_valid == 1'b0, "R11 reset rsp_valid", {63'd0, rsp_valid}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    send(MAIL, {32'hDEAD_BEEF, 6'd0, 10'd1, 16'h0014}, 0, 0, "R4 R6 mail idx5");
    send(MAIL, {32'h1111_2222, 6'd0, 10'd0, 16'hFFE3}, 0, 0, "R4 mail idx0 upper bits ignored");
    send(ANY, {32'h0BAD_F00D, 6'd0, 10'd3, 16'h1234}, 0, 0, "R5 any offset");
    send(ANY, {32'hCAFE_0001, 1'b1, 4'h0, 1'b1, 10'd2, 16'h0800}, 0, 0, "R6 bits 31 26 ignored");
    send(MAIL, {32'hA1B2_C3D4, 1'b0, 4'b0101, 1'b0, 10'd2, 16'h0000}, 0, 0, "R7 keep 0101");
    send(ANY, {32'h5555_AAAA, 1'b0, 4'b1111, 1'b0, 10'd3, 16'h4444}, 0, 0, "R7 keep all");
    send(ANY, {32'h7777_8888, 1'b0, 4'b1000, 1'b0, 10'd1, 16'h0100}, 0, 0, "R7 keep top lane");
    send(MAIL, {32'h1234_5678, 6'd0, 10'd4, 16'h0004}, 0, 0, "R2 core 4 missing");
    send(ANY, {32'h1234_5678, 6'd0, 10'h3FF, 16'h0004}, 0, 0, "R2 core 3FF missing");
    send(8'h14, {32'h1234_5678, 6'd0, 10'd1, 16'h0004}, 0, 0, "R3 bad command address");
    send(ANY, {32'h0F0F_0F0F, 1'b0, 4'b0011, 1'b0, 10'd0, 16'h0200}, 1, 0, "R8 read error");
    send(MAIL, {32'h0F0F_0F0F, 6'd0, 10'd1, 16'h001C}, 0, 1, "R9 write error plain");
    send(ANY, {32'h3C3C_3C3C, 1'b0, 4'b0010, 1'b0, 10'd2, 16'h0300}, 0, 1, "R9 write error merged");
    bp_on = 1;
    send(MAIL, {32'h9999_0000, 1'b0, 4'b0110, 1'b0, 10'd3, 16'h0008}, 0, 0, "R10 backpressure merged");
    send(ANY, {32'h0000_9999, 6'd0, 10'd0, 16'hFFFC}, 0, 0, "R10 backpressure plain");
    send(MAIL, {32'h2468_ACE0, 6'd0, 10'd7, 16'h0000}, 0, 0, "R10 backpressure reject");
    bp_on = 0;
    chk(exp_rsp.size() == 0, "R1 no leftover responses", exp_rsp.size(), 0);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion (%s)", cur_tag);
      finish_run();
    end
  end
endmodule